// File: doc/BRIEF.md
# Variable Page Size Data TLB

This block translates data addresses through a fully associative table of translation entries. Every entry carries a virtual page tag, a context number and a translation word. The translation word holds a valid flag, a two-bit page size, and attribute flags: global, privileged, writable, no-fault-only and side-effect. Each entry has its own page size, so each entry compares a different number of virtual address bits.

A request gives a virtual address, a context selector, an access kind and a user flag. One cycle later the block returns exactly one outcome: a hit with a physical address and a write permission, a miss, a data fault or a protection fault. Faults load a status register, a fault address register and a tag access register. A miss loads only the tag access register, so refill software knows which page to load. Entries are loaded through a plain indexed write port. When translation is disabled, the virtual address passes straight through.

Top module: `vpt_tlb`

## Requirements
- R1: Page size code `s` (0: 8 KB, 1: 64 KB, 2: 512 KB, 3: 4 MB) makes an entry compare only virtual address bits from 13+3·s upward, and all bits up to the top bit take part.
- R2: An entry matches when it is valid, its masked tag equals the masked address, and either its global flag is set or its context equals the selected context. The selector is 0 = primary context input, 1 = secondary context input, 2 or 3 = context zero.
- R3: A hit returns a physical address built from the translation bits at or above 13+3·s and the request address bits below that position. The result is 41 bits wide, and bits 12:0 are forced to zero.
- R4: The access kind is 0 = load, 1 = store, 2 = no-fault load. A data fault is reported when at least one cause applies. The cause bits are: cause bit 0 = user access to a privileged entry; cause bit 1 = no-fault load to a side-effect entry; cause bit 2 = any other kind to a no-fault-only entry. Several cause bits may be set together.
- R5: A store to a non-writable entry that has no data-fault cause reports a protection fault with all cause bits clear.
- R6: On either kind of fault, the overwrite bit takes the previous status valid bit, or zero if the status is being acknowledged in that cycle. The valid bit is then set, the write, no-fault-load, context selector and cause fields are rewritten, and the fault address register takes the full virtual address.
- R7: On a fault or a miss, the tag access register takes the virtual address with bits 12:0 cleared, ORed with the selected context.
- R8: A miss leaves the status fields and the fault address register unchanged.
- R9: With translation disabled, every request hits with write permission, and the physical address is the low 41 bits of the virtual address. No TLB state changes.
- R10: If several entries match, the lowest-numbered entry is used. A hit without a fault sets that entry's used bit. Writing an entry clears its used bit.
- R11: Each request yields exactly one of hit, miss, data fault or protection fault, registered one cycle later. With no request, all outcome flags are low.
- R12: After synchronous reset, all entries are invalid, all used bits are zero, and the response, status, fault address and tag access outputs are zero.
- R13: The status acknowledge input clears the valid and overwrite bits, so the next fault reports no overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable |
| pri_ctx | input | CTX_W | Primary context number |
| sec_ctx | input | CTX_W | Secondary context number |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_va | input | VA_W | Virtual page tag (bits below 13 ignored) |
| wr_ctx | input | CTX_W | Entry context |
| wr_pa | input | PA_W | Translation address (bits below 13 ignored) |
| wr_size | input | 2 | Page size code |
| wr_valid | input | 1 | Entry valid |
| wr_glob | input | 1 | Global entry |
| wr_priv | input | 1 | Privileged entry |
| wr_writable | input | 1 | Entry writable |
| wr_nfo | input | 1 | No-fault-only entry |
| wr_sfx | input | 1 | Side-effect entry |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Lookup virtual address |
| req_ctx_sel | input | 2 | Context selector |
| req_kind | input | 2 | Access kind |
| req_user | input | 1 | User-mode access |
| stat_ack | input | 1 | Acknowledge status |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_dfault | output | 1 | Data fault |
| rsp_prot | output | 1 | Protection fault |
| rsp_pa | output | PA_W | Physical address on hit |
| rsp_wr_ok | output | 1 | Write permitted on hit |
| used_bits | output | ENTRIES | Per-entry used flags |
| stat_valid | output | 1 | Status valid |
| stat_ovw | output | 1 | Status overwritten |
| stat_write | output | 1 | Faulting access was a store |
| stat_nfload | output | 1 | Faulting access was a no-fault load |
| stat_ctx | output | 2 | Faulting context selector |
| stat_cause | output | 3 | Data fault cause bits |
| fault_addr | output | VA_W | Faulting virtual address |
| tag_access | output | VA_W | Refill tag: page address and context |

## Verification
The bench builds the block with eight entries and keeps the 64-bit virtual, 41-bit physical and 13-bit context widths. The small table lets every index be loaded on purpose, including the last one. Two entries with the same tag make the lowest-index rule and the used-bit vector observable bit by bit. The full widths keep the top virtual address bit and the 4 MB mask boundary inside the compared range.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int PG_OFF  = 13;
  localparam int SZ_STEP = 3;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_NFLOAD = 2'd2,
    ACC_RSVD   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CS_PRI = 2'd0,
    CS_SEC = 2'd1,
    CS_NUC = 2'd2,
    CS_NU2 = 2'd3
  } ctxsel_e;

  typedef struct packed {
    logic       glob;
    logic       priv;
    logic       wr;
    logic       nfo;
    logic       sfx;
    logic [1:0] size;
  } attr_t;
endpackage

// File: rtl/vpt_match.sv
module vpt_match #(
  parameter int VPN_W = 51,
  parameter int CTX_W = 13
) (
  input  logic             vld,
  input  logic             glob,
  input  logic [1:0]       size,
  input  logic [VPN_W-1:0] tag_vpn,
  input  logic [CTX_W-1:0] tag_ctx,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [CTX_W-1:0] req_ctx,
  output logic             hit
);
  logic [VPN_W-1:0] care;

  always_comb begin
    care = {VPN_W{1'b1}} << (vpt_pkg::SZ_STEP * int'(size));
    hit  = vld && (((req_vpn ^ tag_vpn) & care) == '0) &&
           (glob || (req_ctx == tag_ctx));
  end
endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
  parameter int N     = 64,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vpt_fault.sv
module vpt_fault (
  input  logic       priv,
  input  logic       wr,
  input  logic       nfo,
  input  logic       sfx,
  input  logic [1:0] kind,
  input  logic       user,
  output logic [2:0] cause,
  output logic       dfault,
  output logic       prot
);
  import vpt_pkg::*;
  logic is_nf;

  always_comb begin
    is_nf    = (acc_e'(kind) == ACC_NFLOAD);
    cause[0] = priv & user;
    cause[1] = is_nf & sfx;
    cause[2] = ~is_nf & nfo;
    dfault   = |cause;
    prot     = ~dfault & (acc_e'(kind) == ACC_STORE) & ~wr;
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xlat_en,
  input  logic [CTX_W-1:0]   pri_ctx,
  input  logic [CTX_W-1:0]   sec_ctx,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VA_W-1:0]    wr_va,
  input  logic [CTX_W-1:0]   wr_ctx,
  input  logic [PA_W-1:0]    wr_pa,
  input  logic [1:0]         wr_size,
  input  logic               wr_valid,
  input  logic               wr_glob,
  input  logic               wr_priv,
  input  logic               wr_writable,
  input  logic               wr_nfo,
  input  logic               wr_sfx,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic [1:0]         req_ctx_sel,
  input  logic [1:0]         req_kind,
  input  logic               req_user,
  input  logic               stat_ack,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_dfault,
  output logic               rsp_prot,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_wr_ok,
  output logic [ENTRIES-1:0] used_bits,
  output logic               stat_valid,
  output logic               stat_ovw,
  output logic               stat_write,
  output logic               stat_nfload,
  output logic [1:0]         stat_ctx,
  output logic [2:0]         stat_cause,
  output logic [VA_W-1:0]    fault_addr,
  output logic [VA_W-1:0]    tag_access
);
  import vpt_pkg::*;

  localparam int VPN_W = VA_W - PG_OFF;
  localparam int PPN_W = PA_W - PG_OFF;

  // Entry storage: wide parallel compare needs flops, not RAM
  logic [VPN_W-1:0] tag_vpn_q [ENTRIES];
  logic [CTX_W-1:0] tag_ctx_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q     [ENTRIES];
  attr_t            attr_q    [ENTRIES];
  logic [ENTRIES-1:0] vld_q, used_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_vpn_q[wr_idx] <= wr_va[VA_W-1:PG_OFF];
      tag_ctx_q[wr_idx] <= wr_ctx;
      ppn_q[wr_idx]     <= wr_pa[PA_W-1:PG_OFF];
      attr_q[wr_idx]    <= '{glob: wr_glob, priv: wr_priv, wr: wr_writable,
                             nfo: wr_nfo, sfx: wr_sfx, size: wr_size};
    end
  end

  // Context selection
  logic [CTX_W-1:0] cur_ctx;
  always_comb begin
    case (ctxsel_e'(req_ctx_sel))
      CS_PRI:  cur_ctx = pri_ctx;
      CS_SEC:  cur_ctx = sec_ctx;
      default: cur_ctx = '0;
    endcase
  end

  // Per-entry compare
  logic [ENTRIES-1:0] hit_vec;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    vpt_match #(.VPN_W(VPN_W), .CTX_W(CTX_W)) u_match (
      .vld     (vld_q[g]),
      .glob    (attr_q[g].glob),
      .size    (attr_q[g].size),
      .tag_vpn (tag_vpn_q[g]),
      .tag_ctx (tag_ctx_q[g]),
      .req_vpn (req_va[VA_W-1:PG_OFF]),
      .req_ctx (cur_ctx),
      .hit     (hit_vec[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] sel_idx;
  vpt_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req (hit_vec),
    .any (any_hit),
    .idx (sel_idx)
  );

  attr_t sel_attr;
  assign sel_attr = attr_q[sel_idx];

  logic [2:0] cause_n;
  logic       dfault_n, prot_n;
  vpt_fault u_fault (
    .priv   (sel_attr.priv),
    .wr     (sel_attr.wr),
    .nfo    (sel_attr.nfo),
    .sfx    (sel_attr.sfx),
    .kind   (req_kind),
    .user   (req_user),
    .cause  (cause_n),
    .dfault (dfault_n),
    .prot   (prot_n)
  );

  // Physical address merge and refill tag
  logic [PPN_W-1:0] pmask, ppn_n;
  logic [PA_W-1:0]  pa_map;
  logic [VA_W-1:0]  ta_n;
  logic             look, bad;
  always_comb begin
    pmask  = {PPN_W{1'b1}} << (SZ_STEP * int'(sel_attr.size));
    ppn_n  = (ppn_q[sel_idx] & pmask) | (req_va[PA_W-1:PG_OFF] & ~pmask);
    pa_map = {ppn_n, {PG_OFF{1'b0}}};
    ta_n   = {req_va[VA_W-1:PG_OFF], {PG_OFF{1'b0}}} | VA_W'(cur_ctx);
    look   = req_valid & xlat_en;
    bad    = dfault_n | prot_n;
  end

  // Entry valid and used flags
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      used_q <= '0;
    end else begin
      if (wr_en) begin
        vld_q[wr_idx]  <= wr_valid;
        used_q[wr_idx] <= 1'b0;
      end
      if (look && any_hit && !bad) used_q[sel_idx] <= 1'b1;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_dfault <= 1'b0;
      rsp_prot   <= 1'b0;
      rsp_pa     <= '0;
      rsp_wr_ok  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid & (~xlat_en | (any_hit & ~bad));
      rsp_miss   <= look & ~any_hit;
      rsp_dfault <= look & any_hit & dfault_n;
      rsp_prot   <= look & any_hit & prot_n;
      rsp_pa     <= xlat_en ? pa_map : req_va[PA_W-1:0];
      rsp_wr_ok  <= req_valid & (~xlat_en | (any_hit & ~bad & sel_attr.wr));
    end
  end

  // Fault status, fault address, refill tag
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid  <= 1'b0;
      stat_ovw    <= 1'b0;
      stat_write  <= 1'b0;
      stat_nfload <= 1'b0;
      stat_ctx    <= '0;
      stat_cause  <= '0;
      fault_addr  <= '0;
      tag_access  <= '0;
    end else begin
      if (stat_ack) begin
        stat_valid <= 1'b0;
        stat_ovw   <= 1'b0;
      end
      if (look && !any_hit) begin
        tag_access <= ta_n;
      end else if (look && bad) begin
        stat_ovw    <= stat_valid & ~stat_ack;
        stat_valid  <= 1'b1;
        stat_write  <= (acc_e'(req_kind) == ACC_STORE);
        stat_nfload <= (acc_e'(req_kind) == ACC_NFLOAD);
        stat_ctx    <= req_ctx_sel;
        stat_cause  <= cause_n;
        fault_addr  <= req_va;
        tag_access  <= ta_n;
      end
    end
  end

  assign used_bits = used_q;
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
  parameter int VA_W = 64,
  parameter int PA_W = 41
) (
  input logic            clk,
  input logic            rst,
  input logic            xlat_en,
  input logic            req_valid,
  input logic            stat_ack,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_dfault,
  input logic            rsp_prot,
  input logic [PA_W-1:0] rsp_pa,
  input logic            stat_valid,
  input logic            stat_ovw,
  input logic            stat_write,
  input logic [VA_W-1:0] fault_addr,
  input logic [VA_W-1:0] tag_access
);
  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_dfault, rsp_prot}) == 1);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_dfault || rsp_prot));
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
  // R3
  pa_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && $past(xlat_en)) |-> rsp_pa[12:0] == 13'd0);
  // R8
  miss_keeps_far_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> $stable(fault_addr));
  // R6
  fault_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_dfault || rsp_prot) |-> stat_valid);
  // R6
  ovw_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ((rsp_dfault || rsp_prot) && $past(stat_valid) && !$past(stat_ack)) |-> stat_ovw);
  // R5
  prot_is_store_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_prot |-> stat_write);
  // R7
  tag_far_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_dfault || rsp_prot) |-> fault_addr[VA_W-1:13] == tag_access[VA_W-1:13]);
endmodule

bind vpt_tlb vpt_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_vpt_tlb.sv
module tb_vpt_tlb;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, xlat_en, wr_en, wr_valid, wr_glob, wr_priv, wr_writable, wr_nfo, wr_sfx;
  logic req_valid, req_user, stat_ack;
  logic [12:0] pri_ctx, sec_ctx, wr_ctx;
  logic [IW-1:0] wr_idx;
  logic [63:0] wr_va, req_va;
  logic [40:0] wr_pa;
  logic [1:0] wr_size, req_ctx_sel, req_kind;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_dfault, rsp_prot, rsp_wr_ok;
  logic [40:0] rsp_pa;
  logic [N-1:0] used_bits;
  logic stat_valid, stat_ovw, stat_write, stat_nfload;
  logic [1:0] stat_ctx;
  logic [2:0] stat_cause;
  logic [63:0] fault_addr, tag_access;

  vpt_tlb #(.ENTRIES(N)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] code();
    if (rsp_hit) return 2'd0;
    if (rsp_miss) return 2'd1;
    if (rsp_dfault) return 2'd2;
    return 2'd3;
  endfunction

  task automatic fill(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                      input logic [40:0] pa, input logic [1:0] sz, input logic v,
                      input logic gl, input logic pr, input logic w, input logic nf,
                      input logic sx);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_va = va; wr_ctx = ctx; wr_pa = pa;
    wr_size = sz; wr_valid = v; wr_glob = gl; wr_priv = pr; wr_writable = w;
    wr_nfo = nf; wr_sfx = sx;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [63:0] va, input logic [1:0] cs,
                      input logic [1:0] kind, input logic user);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_ctx_sel = cs; req_kind = kind; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    stat_ack = 1'b1;
    @(negedge clk);
    stat_ack = 1'b0;
  endtask

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  cs;
    logic [1:0]  kind;
    logic        user;
    logic [1:0]  code;
    logic [40:0] pa;
    logic        wok;
  } vec_t;

  // code: 0 hit, 1 miss, 2 data fault, 3 protection fault
  localparam vec_t VT [15] = '{
    '{64'h0000_0040_0000_A123, 2'd0, 2'd0, 1'b1, 2'd0, 41'h0_1234_6000, 1'b1}, // R3 8 KB
    '{64'h0000_0040_0000_A123, 2'd1, 2'd0, 1'b1, 2'd1, 41'h0,           1'b0}, // R2 ctx mismatch
    '{64'h0000_0000_00A3_5000, 2'd1, 2'd0, 1'b1, 2'd0, 41'h1_0063_4000, 1'b0}, // R1 R2 global 4 MB
    '{64'h0000_0000_00A3_5000, 2'd0, 2'd1, 1'b0, 2'd3, 41'h0,           1'b0}, // R5
    '{64'h0000_0000_3000_E000, 2'd1, 2'd0, 1'b1, 2'd2, 41'h0,           1'b0}, // R4 priv
    '{64'h0000_0000_3000_E000, 2'd1, 2'd0, 1'b0, 2'd0, 41'h0_7777_E000, 1'b1}, // R1 64 KB
    '{64'h0000_0000_500F_F000, 2'd0, 2'd2, 1'b0, 2'd2, 41'h0,           1'b0}, // R4 side effect
    '{64'h0000_0000_500F_F000, 2'd0, 2'd0, 1'b0, 2'd0, 41'h0_2007_E000, 1'b1}, // R1 512 KB
    '{64'h0000_0000_6000_0000, 2'd0, 2'd2, 1'b0, 2'd0, 41'h0_4444_0000, 1'b0}, // R4 nfo allows nf load
    '{64'h0000_0000_6000_0000, 2'd0, 2'd0, 1'b0, 2'd2, 41'h0,           1'b0}, // R4 nfo
    '{64'h0000_0000_7000_0000, 2'd0, 2'd0, 1'b0, 2'd0, 41'h0_0011_0000, 1'b1}, // R10 lowest wins
    '{64'h0000_0000_8000_0000, 2'd2, 2'd0, 1'b0, 2'd0, 41'h0_0033_2000, 1'b1}, // R2 nucleus
    '{64'h0000_0000_8000_0000, 2'd0, 2'd0, 1'b0, 2'd1, 41'h0,           1'b0}, // R2
    '{64'h0000_0000_0040_0000, 2'd0, 2'd0, 1'b0, 2'd1, 41'h0,           1'b0}, // R1 4 MB boundary
    '{64'h8000_0040_0000_A000, 2'd0, 2'd0, 1'b1, 2'd1, 41'h0,           1'b0}  // R1 top bit
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; xlat_en = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_va = '0; wr_ctx = '0;
    wr_pa = '0; wr_size = '0; wr_valid = 1'b0; wr_glob = 1'b0; wr_priv = 1'b0;
    wr_writable = 1'b0; wr_nfo = 1'b0; wr_sfx = 1'b0; req_valid = 1'b0; req_va = '0;
    req_ctx_sel = '0; req_kind = '0; req_user = 1'b0; stat_ack = 1'b0;
    pri_ctx = 13'd5; sec_ctx = 13'd9;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12 stat_valid", 64'(stat_valid), 64'd0);
    chk("R12 used", 64'(used_bits), 64'd0);
    chk("R12 tag_access", tag_access, 64'd0);
    chk("R12 fault_addr", fault_addr, 64'd0);
    xlat_en = 1'b1;
    look(64'h0000_0000_7000_0000, 2'd0, 2'd0, 1'b0);
    chk("R12 empty table miss", 64'(code()), 64'd1);

    fill(0, 64'h0000_0040_0000_A000, 13'd5, 41'h0_1234_6000, 2'd0, 1, 0, 0, 1, 0, 0);
    fill(1, 64'h0000_0000_0080_0000, 13'd0, 41'h1_0040_0000, 2'd3, 1, 1, 0, 0, 0, 0);
    fill(2, 64'h0000_0000_3000_0000, 13'd9, 41'h0_7777_0000, 2'd1, 1, 0, 1, 1, 0, 0);
    fill(3, 64'h0000_0000_5008_0000, 13'd5, 41'h0_2000_0000, 2'd2, 1, 0, 0, 1, 0, 1);
    fill(4, 64'h0000_0000_6000_0000, 13'd5, 41'h0_4444_0000, 2'd0, 1, 0, 1, 0, 1, 0);
    fill(5, 64'h0000_0000_7000_0000, 13'd5, 41'h0_0011_0000, 2'd0, 1, 0, 0, 1, 0, 0);
    fill(6, 64'h0000_0000_7000_0000, 13'd5, 41'h0_0022_0000, 2'd0, 1, 0, 0, 1, 0, 0);
    fill(7, 64'h0000_0000_8000_0000, 13'd0, 41'h0_0033_2000, 2'd0, 1, 0, 0, 1, 0, 0);

    // R10 used bits
    chk("R10 used after fill", 64'(used_bits), 64'd0);
    look(64'h0000_0040_0000_A000, 2'd0, 2'd0, 1'b1);
    chk("R10 used after hit e0", 64'(used_bits), 64'h01);
    look(64'h0000_0000_3000_E000, 2'd1, 2'd0, 1'b1);
    chk("R10 used after fault", 64'(used_bits), 64'h01);
    look(64'h0000_0000_7000_0000, 2'd0, 2'd0, 1'b0);
    chk("R10 used lowest dup", 64'(used_bits), 64'h21);

    // vector table
    for (int i = 0; i < 15; i++) begin
      look(VT[i].va, VT[i].cs, VT[i].kind, VT[i].user);
      chk($sformatf("R11 vec%0d outcome", i), 64'(code()), 64'(VT[i].code));
      if (VT[i].code == 2'd0) begin
        chk($sformatf("R3 vec%0d pa", i), 64'(rsp_pa), 64'(VT[i].pa));
        chk($sformatf("R4 vec%0d wr_ok", i), 64'(rsp_wr_ok), 64'(VT[i].wok));
      end
    end

    // R6 R7 R13 status sequence
    ack();
    chk("R13 ack clears valid", 64'(stat_valid), 64'd0);
    look(64'h0000_0000_3000_E456, 2'd1, 2'd0, 1'b1);
    chk("R6 first valid", 64'(stat_valid), 64'd1);
    chk("R13 first ovw", 64'(stat_ovw), 64'd0);
    chk("R4 first cause", 64'(stat_cause), 64'b001);
    chk("R6 first ctx", 64'(stat_ctx), 64'd1);
    chk("R6 first far", fault_addr, 64'h0000_0000_3000_E456);
    chk("R7 first tag", tag_access, 64'h0000_0000_3000_E009);
    look(64'h0000_0000_6000_0123, 2'd0, 2'd1, 1'b1);
    chk("R4 multi cause outcome", 64'(code()), 64'd2);
    chk("R4 multi cause", 64'(stat_cause), 64'b101);
    chk("R6 second ovw", 64'(stat_ovw), 64'd1);
    chk("R6 second write", 64'(stat_write), 64'd1);
    chk("R6 second far", fault_addr, 64'h0000_0000_6000_0123);
    chk("R7 second tag", tag_access, 64'h0000_0000_6000_0005);
    look(64'h0000_0000_9000_0ABC, 2'd0, 2'd0, 1'b0);
    chk("R8 miss outcome", 64'(code()), 64'd1);
    chk("R8 far kept", fault_addr, 64'h0000_0000_6000_0123);
    chk("R8 cause kept", 64'(stat_cause), 64'b101);
    chk("R7 miss tag", tag_access, 64'h0000_0000_9000_0005);

    // R9 translation disabled
    xlat_en = 1'b0;
    look(64'hFFFF_FFFF_FFFF_F123, 2'd0, 2'd1, 1'b1);
    chk("R9 hit", 64'(code()), 64'd0);
    chk("R9 pa", 64'(rsp_pa), 64'h1FF_FFFF_F123);
    chk("R9 wr_ok", 64'(rsp_wr_ok), 64'd1);
    chk("R9 tag untouched", tag_access, 64'h0000_0000_9000_0005);
    xlat_en = 1'b1;

    // R2 invalid entry
    fill(7, 64'h0000_0000_8000_0000, 13'd0, 41'h0_0033_2000, 2'd0, 0, 0, 0, 1, 0, 0);
    look(64'h0000_0000_8000_0000, 2'd2, 2'd0, 1'b0);
    chk("R2 invalid entry miss", 64'(code()), 64'd1);
    @(negedge clk);
    chk("R11 idle no outcome", 64'({rsp_hit, rsp_miss, rsp_dfault, rsp_prot}), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule